// File: doc/BRIEF.md
# Data Cache Miss Hold Controller

This block sits on the integer-pipeline side of a data cache. The pipeline is in order, with execute (E), result (R) and write (W) stages. When the cache finds a miss on the memory op in R, it raises a miss-hold signal for the whole refill. The block turns that signal into a pipeline stall. It raises a capture enable for returned load data. It also chooses which of three address sources drives the cache address port.

The pipeline does not freeze for the whole miss. It stays stalled only until the load data comes back. After that it keeps running until some memory op reaches W, where it waits for the hold to end. An atomic load-store op in R keeps the pipeline frozen for the whole hold, so that its store half can finish. The cache latches its address on every clock. For that reason, on a stall that does not come from the miss, the W-stage address is sent back onto the E-stage address path. A one-bit flag records that the data for the current miss has already arrived.

Top module: `dcache_miss_hold_ctrl`

## Requirements
- R1: Synchronous active-high `rst` clears `data_seen` to 0 at the next clock edge.
- R2: `data_seen` rises on the clock edge after a cycle with both `miss_hold` and `data_strobe` high. It stays 1 while `miss_hold` stays high and drops on the edge after a cycle with `miss_hold` low. A strobe while `miss_hold` is low leaves it at 0.
- R3: `load_capture` is high exactly in the cycles where `data_strobe` and `miss_hold` are both high.
- R4: While `miss_hold` is high and `data_seen` is 0, `stall` is high. This includes the strobe cycle.
- R5: While `miss_hold` is high and `data_seen` is 1, `stall` is low if all three of these hold: `w_class` is none, `r_class` is not atomic, and `ext_hold` is low.
- R6: While `miss_hold` is high and `w_class` is not none, `stall` is high.
- R7: While `miss_hold` is high and `r_class` is atomic, `stall` is high, even after the data has arrived.
- R8: `ext_hold` high forces `stall` high.
- R9: While `miss_hold` is high and `hold_last` is low, `addr_sel` is 3'b100 (miss address register).
- R10: Otherwise, `addr_sel` is 3'b010 (current address register) when `stall` is high, and 3'b001 (ALU address) when it is low. Exactly one bit of `addr_sel` is set in every cycle.
- R11: `e_addr` equals `w_addr` when `ext_hold` is high and `miss_hold` is low. In every other cycle it equals `alu_addr`.
- R12: `cache_addr` equals `miss_addr`, `cur_addr` or `e_addr`, following the one-hot `addr_sel`.

Op class encoding for `r_class` and `w_class`: 2'b00 none, 2'b01 load, 2'b10 store, 2'b11 atomic load-store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_hold | input | 1 | Cache miss hold in progress |
| data_strobe | input | 1 | Load data from the refill is valid this cycle |
| hold_last | input | 1 | Final cycle of the miss hold |
| ext_hold | input | 1 | Stall request from a source other than the miss |
| r_class | input | 2 | Memory-op class of the R-stage instruction |
| w_class | input | 2 | Memory-op class of the W-stage instruction |
| alu_addr | input | ADDR_W | Address generated in E |
| cur_addr | input | ADDR_W | Current address register |
| miss_addr | input | ADDR_W | Miss address register |
| w_addr | input | ADDR_W | W-stage address register |
| stall | output | 1 | Pipeline stall |
| load_capture | output | 1 | Register the returned load data |
| data_seen | output | 1 | Data for the current miss already received |
| addr_sel | output | 3 | One-hot select: [0] ALU, [1] current, [2] miss |
| e_addr | output | ADDR_W | E-stage address after W replay |
| cache_addr | output | ADDR_W | Address sent to the cache |

## Verification
The bench runs a load miss through its full life, from strobe through release to the final hold cycle. A design that released one cycle early would drop `stall` in the strobe cycle. A design that never released would keep `stall` high after `data_seen` rises. Store and atomic cases check the two reasons to stay stalled after the data has arrived; missing either would let a memory op leave W, or let the store half of a swap pass, during the refill. Separate cases check that a strobe outside a hold is ignored, that the last hold cycle hands the address to the current or ALU path, and that W replay happens only on stalls that do not come from the miss. Replaying on a miss stall would put the wrong address on `cache_addr`.

// File: rtl/mhc_pkg.sv
package mhc_pkg;
  typedef enum logic [1:0] {
    OPC_NONE   = 2'b00,
    OPC_LOAD   = 2'b01,
    OPC_STORE  = 2'b10,
    OPC_ATOMIC = 2'b11
  } op_class_e;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    ASEL_ALU  = 3'b001,
    ASEL_CUR  = 3'b010,
    ASEL_MISS = 3'b100
  } addr_sel_e;
endpackage

// File: rtl/mhc_data_flag.sv
module mhc_data_flag (
  input  logic clk,
  input  logic rst,
  input  logic miss_hold,
  input  logic data_strobe,
  output logic data_seen
);
  logic flag_q;

  // Free-running: updated every clock, no stall enable.
  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= miss_hold & (data_strobe | flag_q);
  end

  assign data_seen = flag_q;

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !data_seen);
  p_set_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (miss_hold && data_strobe) |=> data_seen);
  p_clear_after_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !miss_hold |=> !data_seen);
endmodule

// File: rtl/mhc_stall_logic.sv
module mhc_stall_logic
  import mhc_pkg::*;
(
  input  logic      miss_hold,
  input  logic      data_strobe,
  input  logic      data_seen,
  input  logic      ext_hold,
  input  op_class_e r_class,
  input  op_class_e w_class,
  output logic      stall,
  output logic      load_capture
);
  logic wait_data;
  logic w_is_mem;
  logic r_is_atomic;
  logic miss_stall;

  always_comb begin
    wait_data    = !data_seen;
    w_is_mem     = (w_class != OPC_NONE);
    r_is_atomic  = (r_class == OPC_ATOMIC);
    miss_stall   = miss_hold & (wait_data | w_is_mem | r_is_atomic);
    stall        = ext_hold | miss_stall;
    load_capture = miss_hold & data_strobe;
  end
endmodule

// File: rtl/mhc_addr_path.sv
module mhc_addr_path
  import mhc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              miss_hold,
  input  logic              hold_last,
  input  logic              stall,
  input  logic              ext_hold,
  input  logic [ADDR_W-1:0] alu_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [ADDR_W-1:0] w_addr,
  output addr_sel_e         sel,
  output logic [ADDR_W-1:0] e_addr,
  output logic [ADDR_W-1:0] cache_addr
);
  logic replay;

  always_comb begin
    if (miss_hold && !hold_last) sel = ASEL_MISS;
    else if (stall)              sel = ASEL_CUR;
    else                         sel = ASEL_ALU;
  end

  assign replay = ext_hold & ~miss_hold;
  assign e_addr = replay ? w_addr : alu_addr;

  // One-hot AND-OR mux, one slice per address bit.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    assign cache_addr[b] = (sel[0] & e_addr[b])
                         | (sel[1] & cur_addr[b])
                         | (sel[2] & miss_addr[b]);
  end
endmodule

// File: rtl/dcache_miss_hold_ctrl.sv
module dcache_miss_hold_ctrl
  import mhc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_hold,
  input  logic              data_strobe,
  input  logic              hold_last,
  input  logic              ext_hold,
  input  logic [1:0]        r_class,
  input  logic [1:0]        w_class,
  input  logic [ADDR_W-1:0] alu_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [ADDR_W-1:0] w_addr,
  output logic              stall,
  output logic              load_capture,
  output logic              data_seen,
  output logic [2:0]        addr_sel,
  output logic [ADDR_W-1:0] e_addr,
  output logic [ADDR_W-1:0] cache_addr
);
  addr_sel_e sel_e;

  mhc_data_flag u_flag (
    .clk         (clk),
    .rst         (rst),
    .miss_hold   (miss_hold),
    .data_strobe (data_strobe),
    .data_seen   (data_seen)
  );

  mhc_stall_logic u_stall (
    .miss_hold    (miss_hold),
    .data_strobe  (data_strobe),
    .data_seen    (data_seen),
    .ext_hold     (ext_hold),
    .r_class      (op_class_e'(r_class)),
    .w_class      (op_class_e'(w_class)),
    .stall        (stall),
    .load_capture (load_capture)
  );

  mhc_addr_path #(.ADDR_W(ADDR_W)) u_addr (
    .miss_hold  (miss_hold),
    .hold_last  (hold_last),
    .stall      (stall),
    .ext_hold   (ext_hold),
    .alu_addr   (alu_addr),
    .cur_addr   (cur_addr),
    .miss_addr  (miss_addr),
    .w_addr     (w_addr),
    .sel        (sel_e),
    .e_addr     (e_addr),
    .cache_addr (cache_addr)
  );

  assign addr_sel = sel_e;

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(addr_sel) == 1);
  p_wmem_stalls_r6: assert property (@(posedge clk) disable iff (rst)
    (miss_hold && w_class != 2'b00) |-> stall);
  p_atomic_stalls_r7: assert property (@(posedge clk) disable iff (rst)
    (miss_hold && r_class == 2'b11) |-> stall);
  p_miss_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (miss_hold && !hold_last) |-> addr_sel == 3'b100);
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (miss_hold && data_seen && w_class == 2'b00 && r_class != 2'b11 && !ext_hold)
      |-> !stall);
  p_ext_stall_r8: assert property (@(posedge clk) disable iff (rst)
    ext_hold |-> stall);
endmodule

// File: tb/dcache_miss_hold_ctrl_bench.sv
`timescale 1ns/100ps
module dcache_miss_hold_ctrl_bench;
  localparam int AW = 16;
  localparam logic [1:0] C_NONE = 2'b00, C_LOAD = 2'b01, C_STORE = 2'b10, C_ATOM = 2'b11;
  localparam logic [AW-1:0] A_ALU = 16'h1111, A_CUR = 16'h2222,
                            A_MISS = 16'h3333, A_W = 16'h4444;

  logic clk = 1'b0;
  logic rst, miss_hold, data_strobe, hold_last, ext_hold;
  logic [1:0] r_class, w_class;
  logic [AW-1:0] alu_addr, cur_addr, miss_addr, w_addr;
  logic stall, load_capture, data_seen;
  logic [2:0] addr_sel;
  logic [AW-1:0] e_addr, cache_addr;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dcache_miss_hold_ctrl #(.ADDR_W(AW)) u_dcache_miss_hold_ctrl (
    .clk(clk), .rst(rst), .miss_hold(miss_hold), .data_strobe(data_strobe),
    .hold_last(hold_last), .ext_hold(ext_hold), .r_class(r_class), .w_class(w_class),
    .alu_addr(alu_addr), .cur_addr(cur_addr), .miss_addr(miss_addr), .w_addr(w_addr),
    .stall(stall), .load_capture(load_capture), .data_seen(data_seen),
    .addr_sel(addr_sel), .e_addr(e_addr), .cache_addr(cache_addr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic mh, input logic ds, input logic hl,
                       input logic eh, input logic [1:0] rc, input logic [1:0] wc);
    miss_hold = mh; data_strobe = ds; hold_last = hl;
    ext_hold = eh; r_class = rc; w_class = wc;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(1, 1, 0, 0, C_LOAD, C_NONE);
    step();
    rst = 1'b0;
    drive(0, 0, 0, 0, C_NONE, C_NONE);
    chk("R1 data_seen after reset", data_seen, 0);
    chk("R10 idle stall", stall, 0);
    chk("R10 idle select alu", addr_sel, 3'b001);
    chk("R12 idle cache addr", cache_addr, A_ALU);
    // flag set, then reset mid-hold
    drive(1, 1, 0, 0, C_LOAD, C_NONE);
    step();
    chk("R2 flag set before reset", data_seen, 1);
    rst = 1'b1; drive(1, 0, 0, 0, C_LOAD, C_NONE);
    step();
    rst = 1'b0; drive(0, 0, 0, 0, C_NONE, C_NONE);
    chk("R1 reset clears flag", data_seen, 0);
    step();
  endtask

  task automatic t_load_miss();
    drive(1, 0, 0, 0, C_LOAD, C_NONE);
    chk("R4 stall before data", stall, 1);
    chk("R9 select miss reg", addr_sel, 3'b100);
    chk("R12 cache addr miss", cache_addr, A_MISS);
    chk("R3 no capture w/o strobe", load_capture, 0);
    step();
    drive(1, 1, 0, 0, C_LOAD, C_NONE);
    chk("R3 capture on strobe", load_capture, 1);
    chk("R4 stall in strobe cycle", stall, 1);
    chk("R2 flag not yet set", data_seen, 0);
    step();
    drive(1, 0, 0, 0, C_NONE, C_NONE);
    chk("R2 flag set after strobe", data_seen, 1);
    chk("R5 released after data", stall, 0);
    chk("R9 still miss reg", addr_sel, 3'b100);
    step();
    drive(1, 0, 1, 0, C_NONE, C_NONE);
    chk("R2 flag held", data_seen, 1);
    chk("R10 last cycle alu select", addr_sel, 3'b001);
    chk("R12 last cycle cache addr", cache_addr, A_ALU);
    step();
    drive(0, 0, 0, 0, C_NONE, C_NONE);
    chk("R2 flag still 1 first idle cycle", data_seen, 1);
    step();
    chk("R2 flag cleared after hold", data_seen, 0);
  endtask

  task automatic t_store_in_w();
    drive(1, 1, 0, 0, C_LOAD, C_NONE);
    step();
    drive(1, 0, 0, 0, C_NONE, C_STORE);
    chk("R6 store in W stalls", stall, 1);
    step();
    drive(1, 0, 1, 0, C_NONE, C_LOAD);
    chk("R6 load in W stalls on last", stall, 1);
    chk("R10 last cycle stalled -> current", addr_sel, 3'b010);
    chk("R12 cache addr current", cache_addr, A_CUR);
    step();
    drive(0, 0, 0, 0, C_NONE, C_STORE);
    chk("R6 no stall without hold", stall, 0);
    step(); step();
  endtask

  task automatic t_atomic();
    drive(1, 1, 0, 0, C_ATOM, C_NONE);
    chk("R7 atomic stall on strobe", stall, 1);
    step();
    drive(1, 0, 0, 0, C_ATOM, C_NONE);
    chk("R2 flag set for atomic", data_seen, 1);
    chk("R7 atomic stays stalled", stall, 1);
    step();
    drive(1, 0, 1, 0, C_ATOM, C_NONE);
    chk("R7 atomic stalled last cycle", stall, 1);
    step();
    drive(0, 0, 0, 0, C_NONE, C_NONE);
    step(); step();
  endtask

  task automatic t_ext_hold();
    drive(0, 0, 0, 1, C_NONE, C_NONE);
    chk("R8 external stall", stall, 1);
    chk("R10 external -> current", addr_sel, 3'b010);
    chk("R11 replay W address", e_addr, A_W);
    chk("R12 cache addr current", cache_addr, A_CUR);
    drive(1, 0, 0, 1, C_LOAD, C_NONE);
    chk("R11 no replay during miss", e_addr, A_ALU);
    chk("R9 miss wins select", addr_sel, 3'b100);
    drive(0, 0, 0, 0, C_NONE, C_NONE);
    chk("R11 no replay when free", e_addr, A_ALU);
    step();
  endtask

  task automatic t_stray_strobe();
    drive(0, 1, 0, 0, C_LOAD, C_NONE);
    chk("R3 stray strobe no capture", load_capture, 0);
    step();
    drive(0, 0, 0, 0, C_NONE, C_NONE);
    chk("R2 stray strobe ignored", data_seen, 0);
    drive(1, 0, 0, 0, C_LOAD, C_NONE);
    chk("R4 new miss stalls", stall, 1);
    step();
    drive(0, 0, 0, 0, C_NONE, C_NONE);
    step();
  endtask

  initial begin
    alu_addr = A_ALU; cur_addr = A_CUR; miss_addr = A_MISS; w_addr = A_W;
    rst = 1'b1;
    drive(0, 0, 0, 0, C_NONE, C_NONE);
    step();
    t_reset();
    t_load_miss();
    t_store_in_w();
    t_atomic();
    t_ext_hold();
    t_stray_strobe();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule